// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 64 active-high, level-sensitive interrupt sources and merges them into two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Sources sit in two banks of 32. The upper bank exists only when the `HAS_UPPER` parameter is set. Every source has its own unmask bit and its own routing bit. The routing bit picks which of the two outputs the source drives.

Software uses a simple 32-bit register port with a byte address and a write strobe. Reads are combinational on the address. For each output, software can read the raw level view, the masked and routed view of each bank, and the index of the lowest-numbered pending source. A pending bit cannot be cleared by writing to it. It follows the synchronized source level, so an interrupt goes away only when its source deasserts. Each source input passes through a two-flop synchronizer. Each output is registered.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the unmask and routing registers of both banks read 0, both outputs are low, and both winner registers read 0.
- R2: The raw view reads the source levels after two clock edges. Offset 0x00 holds sources 0..31. Bit n is source n.
- R3: The unmask register reads back what was written to it. Offset 0x04 is the lower bank and 0x24 is the upper bank. A source whose unmask bit is 0 shows in neither routed view. Writing 0 silences the whole bank.
- R4: The routing registers are at offset 0x08 (lower) and 0x28 (upper). The normal-request view is raw & unmask & ~route, read at 0x0C (lower) and 0x2C (upper). The fast-request view is raw & unmask & route, read at 0x10 (lower) and 0x30 (upper).
- R5: `irq_o` is the OR of both normal-request views. `fiq_o` is the OR of both fast-request views. Each output goes high or low one clock edge after its views change.
- R6: Offset 0x18 holds the normal-request winner and offset 0x1C holds the fast-request winner. Each reads 0x80000000 | k, where k is the lowest-numbered pending source in that view across both banks. A winner register reads 0 when its view is empty.
- R7: Source n of 32 or more appears at bit n-32 of the upper-bank registers. The upper raw view is at offset 0x20.
- R8: A pending bit stays set while its source is held high, even if its view is written. The bit clears only after the source deasserts.
- R9: Writes to read-only offsets have no effect. These are 0x00, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x20, 0x2C and 0x30, plus unmapped offsets. Offset 0x14 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of register access |
| bus_wr | input | 1 | Write strobe, sampled at clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_i | input | 64 | Raw interrupt source levels |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A register write can change unmask or routing in the same cycle that a synchronized source level changes. Both changes then land in the routed views and the winner registers together. The bench provokes this by writing unmask or routing while sources are active, and by moving sources between random configurations. After each step it compares every view, both winner registers and both outputs with values computed from its own copy of the written registers. The output latency is checked one edge at a time against the synchronizer and output register delays.

// File: rtl/lic_pkg.sv
// Package: shared sizes and register offsets for the level interrupt controller.
// Assumes byte addressing with 32-bit registers.
package lic_pkg;
    localparam int BANK_W  = 32;
    localparam int NSRC    = 2 * BANK_W;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] A_RAW_LO  = 8'h00;
    localparam logic [ADDR_W-1:0] A_EN_LO   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SEL_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] A_IRQ_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_FIQ_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_PRIO    = 8'h14;
    localparam logic [ADDR_W-1:0] A_IRQ_WIN = 8'h18;
    localparam logic [ADDR_W-1:0] A_FIQ_WIN = 8'h1C;
    localparam logic [ADDR_W-1:0] A_RAW_HI  = 8'h20;
    localparam logic [ADDR_W-1:0] A_EN_HI   = 8'h24;
    localparam logic [ADDR_W-1:0] A_SEL_HI  = 8'h28;
    localparam logic [ADDR_W-1:0] A_IRQ_HI  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_FIQ_HI  = 8'h30;

    typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/lic_sync.sv
// Module: two-flop synchronizer for a vector of independent level inputs.
// Assumes each bit is a slow level; bits are not sampled coherently with each other.
module lic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the inputs through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/lic_bank.sv
// Module: one bank of sources. It holds the unmask and routing registers and
// forms the two routed views. Assumes raw_i is already synchronized.
module lic_bank
    import lic_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] irq_st_o,
    output logic [W-1:0] fiq_st_o
);
    logic [W-1:0] en_q;
    logic [W-1:0] sel_q;

    // Hold the unmask and routing registers; both clear to masked, normal route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (wr_en_i)  en_q  <= wdata_i;
            if (wr_sel_i) sel_q <= wdata_i;
        end
    end

    // Split the unmasked levels by routing bit.
    always_comb begin
        irq_st_o = raw_i & en_q & ~sel_q;
        fiq_st_o = raw_i & en_q &  sel_q;
    end

    assign en_o  = en_q;
    assign sel_o = sel_q;
endmodule

// File: rtl/lic_prio.sv
// Module: finds the lowest set bit of a vector and encodes it as an index.
// Assumes lower index means higher priority.
module lic_prio #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest set bit is written last and wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        valid_o = |vec_i;
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: top of the dual-output level interrupt controller. It decodes the register
// port, builds one or two source banks, and finds a winner per output.
// Assumes a single-cycle write strobe and a combinational read of bus_addr.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter bit HAS_UPPER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       src_i,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int PAD_W = DATA_W - 1 - IDX_W;

    bank_t raw_lo, en_lo, sel_lo, irq_lo, fiq_lo;
    bank_t raw_hi, en_hi, sel_hi, irq_hi, fiq_hi;
    logic [NSRC-1:0] irq_all, fiq_all, en_all;
    logic            irq_win_v, fiq_win_v;
    logic [IDX_W-1:0] irq_win_i, fiq_win_i;
    logic [DATA_W-1:0] irq_hp_w, fiq_hp_w;
    logic irq_q, fiq_q;

    lic_sync #(.W(BANK_W)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .d_i(src_i[BANK_W-1:0]), .q_o(raw_lo)
    );

    lic_bank #(.W(BANK_W)) u_bank_lo (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_lo),
        .wr_en_i(bus_wr && bus_addr == A_EN_LO),
        .wr_sel_i(bus_wr && bus_addr == A_SEL_LO),
        .wdata_i(bus_wdata),
        .en_o(en_lo), .sel_o(sel_lo), .irq_st_o(irq_lo), .fiq_st_o(fiq_lo)
    );

    generate
        if (HAS_UPPER) begin : g_upper
            lic_sync #(.W(BANK_W)) u_sync_hi (
                .clk(clk), .rst_n(rst_n), .d_i(src_i[NSRC-1:BANK_W]), .q_o(raw_hi)
            );
            lic_bank #(.W(BANK_W)) u_bank_hi (
                .clk(clk), .rst_n(rst_n), .raw_i(raw_hi),
                .wr_en_i(bus_wr && bus_addr == A_EN_HI),
                .wr_sel_i(bus_wr && bus_addr == A_SEL_HI),
                .wdata_i(bus_wdata),
                .en_o(en_hi), .sel_o(sel_hi), .irq_st_o(irq_hi), .fiq_st_o(fiq_hi)
            );
        end else begin : g_no_upper
            assign raw_hi = '0;
            assign en_hi  = '0;
            assign sel_hi = '0;
            assign irq_hi = '0;
            assign fiq_hi = '0;
        end
    endgenerate

    assign irq_all = {irq_hi, irq_lo};
    assign fiq_all = {fiq_hi, fiq_lo};
    assign en_all  = {en_hi, en_lo};

    lic_prio #(.N(NSRC), .IW(IDX_W)) u_prio_irq (
        .vec_i(irq_all), .valid_o(irq_win_v), .idx_o(irq_win_i)
    );
    lic_prio #(.N(NSRC), .IW(IDX_W)) u_prio_fiq (
        .vec_i(fiq_all), .valid_o(fiq_win_v), .idx_o(fiq_win_i)
    );

    // Format each winner as valid flag in bit 31 plus index, or all zero.
    always_comb begin
        irq_hp_w = irq_win_v ? {1'b1, {PAD_W{1'b0}}, irq_win_i} : '0;
        fiq_hp_w = fiq_win_v ? {1'b1, {PAD_W{1'b0}}, fiq_win_i} : '0;
    end

    // Register the merged requests to give clean processor inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_all;
            fiq_q <= |fiq_all;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    // Select read data by address; priority and unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            A_RAW_LO:  bus_rdata = raw_lo;
            A_EN_LO:   bus_rdata = en_lo;
            A_SEL_LO:  bus_rdata = sel_lo;
            A_IRQ_LO:  bus_rdata = irq_lo;
            A_FIQ_LO:  bus_rdata = fiq_lo;
            A_IRQ_WIN: bus_rdata = irq_hp_w;
            A_FIQ_WIN: bus_rdata = fiq_hp_w;
            A_RAW_HI:  bus_rdata = raw_hi;
            A_EN_HI:   bus_rdata = en_hi;
            A_SEL_HI:  bus_rdata = sel_hi;
            A_IRQ_HI:  bus_rdata = irq_hi;
            A_FIQ_HI:  bus_rdata = fiq_hi;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lic_checker.sv
// Module: property checker for lvl_irq_ctrl, attached by bind.
// Assumes the internal view, unmask and winner nets of the top are visible by name.
module lic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_o,
    input logic        fiq_o,
    input logic [63:0] irq_stat,
    input logic [63:0] fiq_stat,
    input logic [63:0] en_all,
    input logic [31:0] irq_hp,
    input logic [31:0] fiq_hp
);
    // R4
    route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & fiq_stat) == 64'd0);
    // R3
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_stat | fiq_stat) & ~en_all) == 64'd0);
    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_stat) |=> irq_o);
    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_stat) |=> !irq_o);
    // R5
    fiq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fiq_stat) |=> fiq_o);
    // R5
    fiq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fiq_stat) |=> !fiq_o);
    // R6
    irq_win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hp[31] == (|irq_stat));
    // R6
    irq_win_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hp[31] |-> irq_stat[irq_hp[5:0]]);
    // R6
    fiq_win_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_hp[31] |-> fiq_stat[fiq_hp[5:0]]);
endmodule

bind lvl_irq_ctrl lic_checker u_lic_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_stat(irq_all), .fiq_stat(fiq_all), .en_all(en_all),
    .irq_hp(irq_hp_w), .fiq_hp(fiq_hp_w)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [63:0] src_i = 64'h0;
    logic        irq_o, fiq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [63:0] m_en = 64'h0;
    logic [63:0] m_sel = 64'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl u_lvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] win(input logic [63:0] v);
        for (int i = 0; i < 64; i++)
            if (v[i]) return 32'h8000_0000 | 32'(i);
        return 32'h0;
    endfunction

    function automatic logic [63:0] exp_irq();
        return src_i & m_en & ~m_sel;
    endfunction

    function automatic logic [63:0] exp_fiq();
        return src_i & m_en & m_sel;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h04) m_en[31:0]  = d;
        if (a == 8'h24) m_en[63:32] = d;
        if (a == 8'h08) m_sel[31:0]  = d;
        if (a == 8'h28) m_sel[63:32] = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [63:0] ei, ef;
        ei = exp_irq(); ef = exp_fiq();
        rd(8'h00, v); chk({tag, " R2 raw lo"}, v, src_i[31:0]);
        rd(8'h20, v); chk({tag, " R7 raw hi"}, v, src_i[63:32]);
        rd(8'h04, v); chk({tag, " R3 en lo"}, v, m_en[31:0]);
        rd(8'h24, v); chk({tag, " R3 en hi"}, v, m_en[63:32]);
        rd(8'h08, v); chk({tag, " R4 sel lo"}, v, m_sel[31:0]);
        rd(8'h28, v); chk({tag, " R4 sel hi"}, v, m_sel[63:32]);
        rd(8'h0C, v); chk({tag, " R4 irq lo"}, v, ei[31:0]);
        rd(8'h10, v); chk({tag, " R4 fiq lo"}, v, ef[31:0]);
        rd(8'h2C, v); chk({tag, " R7 irq hi"}, v, ei[63:32]);
        rd(8'h30, v); chk({tag, " R7 fiq hi"}, v, ef[63:32]);
        rd(8'h18, v); chk({tag, " R6 irq win"}, v, win(ei));
        rd(8'h1C, v); chk({tag, " R6 fiq win"}, v, win(ef));
        chk({tag, " R5 irq_o"}, {31'h0, irq_o}, {31'h0, |ei});
        chk({tag, " R5 fiq_o"}, {31'h0, fiq_o}, {31'h0, |ef});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, v); chk("R1 en lo", v, 32'h0);
        rd(8'h08, v); chk("R1 sel lo", v, 32'h0);
        rd(8'h24, v); chk("R1 en hi", v, 32'h0);
        rd(8'h28, v); chk("R1 sel hi", v, 32'h0);
        rd(8'h18, v); chk("R1 irq win", v, 32'h0);
        rd(8'h1C, v); chk("R1 fiq win", v, 32'h0);
        chk("R1 outs", {30'h0, irq_o, fiq_o}, 32'h0);

        // R2/R5 latency: synchronizer then output register
        wr(8'h04, 32'h0000_0001);
        src_i[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        rd(8'h00, v); chk("R2 raw after one edge", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(8'h00, v); chk("R2 raw after two edges", v, 32'h1);
        chk("R5 irq_o not yet", {31'h0, irq_o}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R5 irq_o one edge later", {31'h0, irq_o}, 32'h1);

        // R8 pending held while level high, writes do nothing
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); chk("R8 irq lo held", v, 32'h1);
        src_i[0] = 1'b0;
        settle();
        rd(8'h0C, v); chk("R8 cleared by source", v, 32'h0);
        chk("R8 irq_o low", {31'h0, irq_o}, 32'h0);

        // R4 fast route and R6 winner
        wr(8'h04, 32'h0000_0028);
        wr(8'h08, 32'h0000_0020);
        src_i[5] = 1'b1; src_i[3] = 1'b1;
        settle();
        check_all("fast route");

        // R7 upper bank, R6 cross-bank order
        wr(8'h24, 32'h0000_0100);
        src_i[40] = 1'b1;
        settle();
        check_all("upper bank");
        src_i[3] = 1'b0;
        settle();
        rd(8'h18, v); chk("R6 R7 upper winner", v, 32'h8000_0028);

        // R9 read-only and unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R9 prio reads zero", v, 32'h0);
        rd(8'h34, v); chk("R9 unmapped 0x34", v, 32'h0);
        rd(8'h3C, v); chk("R9 unmapped 0x3C", v, 32'h0);
        check_all("R9 after ignored writes");

        // R3 whole-bank silence with sources active
        src_i[31:0] = 32'hFFFF_FFFF;
        wr(8'h04, 32'h0);
        settle();
        rd(8'h0C, v); chk("R3 lo silenced irq", v, 32'h0);
        rd(8'h10, v); chk("R3 lo silenced fiq", v, 32'h0);
        check_all("R3 silence");

        // Random configurations, sometimes rewriting while sources move
        for (int it = 0; it < 60; it++) begin
            wr(8'h04, $urandom());
            wr(8'h08, $urandom());
            wr(8'h24, $urandom() & $urandom());
            wr(8'h28, $urandom());
            src_i = {$urandom() & $urandom(), $urandom() & $urandom() & $urandom()};
            if (it % 4 == 0) src_i = 64'h0;
            if (it % 7 == 0) wr(8'h04, 32'h0);
            settle();
            check_all("random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule